// File: doc/BRIEF.md
# Local-to-PCI Window Address Translator

This block turns a 32-bit address from the local bus into a PCI address. It holds up to six address windows. Each window has a base address, a high address and a space designator, and each window must cover a contiguous power-of-two range whose base is aligned to that size. An incoming address is compared against every active window. If one matches, the bits of the address that the window's base and high address share at the top are replaced with the same bits of that window's translation vector. All bits below them pass through unchanged. The block also reports which window matched and whether the target is PCI memory or PCI I/O space.

The translation vectors come from one of two sources, chosen at build time. They are either elaboration parameters, which cost no storage, or one register per window that software writes through a small write port so that windows can be remapped at run time. Addresses enter on a valid/ready stream and results leave on a valid/ready stream. There is a single output register stage. An address is accepted whenever the output register is empty or is being emptied in the same cycle. When the consumer stalls, the output holds its value and input acceptance stops, so back-pressure passes straight through to the producer.

Top module: `pci_window_xlate`

## Requirements
- R1: Only windows 0 to NUM_WIN-1 take part in matching, with NUM_WIN between 1 and 6. An address that lies only inside a window numbered NUM_WIN or above is reported as a miss.
- R2: An address matches window i when its top K bits equal the top K bits of that window's base. K is the number of leading bit positions, counted from bit 31, in which the window's base and high address agree. Addresses one below the base do not match, while the base itself and the high address do.
- R3: On a match, out_addr takes its top K bits from the window's translation vector and its remaining low bits from in_addr. For example, window 0x12340000–0x1234FFFF with vector 0x5671xxxx maps 0x12340ABC to 0x56710ABC. Window 0xABCDE000–0xABCDFFFF with vector 0xFEDC0xxx maps 0xABCDF123 to 0xFEDC1123. Window 0xFE000000–0xFFFFFFFF with vector 0x40xxxxxx maps 0xFFFEDCBA to 0x41FEDCBA. Window 0x00000000–0x0000007F with vector 0x8765438x maps 0x00000071 to 0x876543F1.
- R4: On a match, out_is_mem carries the matching window's designator: 1 means PCI memory space and 0 means PCI I/O space. out_win carries the window number as an unsigned binary value.
- R5: When several active windows match, the lowest-numbered one supplies the result.
- R6: When no active window matches, out_miss is 1 and out_addr, out_win and out_is_mem keep the values of the previous result. On a match, out_miss is 0.
- R7: A result appears with out_valid high in the cycle after its address is accepted (in_valid and in_ready both high at a clock edge). Results leave in acceptance order. out_valid falls after a result is taken if no new address is accepted in that cycle.
- R8: in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, all outputs hold their values.
- R9: With USE_REG_VEC = 0, vectors come from the WIN_VEC parameter and writes on the vector port have no effect on translation.
- R10: With USE_REG_VEC = 1, each active window has a 32-bit vector register that is 0x00000000 after reset. A cycle with vec_we high loads vec_wdata into the register of window vec_idx (binary index), and later translations use it.
- R11: While rst_n is low and right after it rises, out_valid, out_miss, out_is_mem, out_win and out_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request address is valid |
| in_ready | output | 1 | Block accepts the request this cycle |
| in_addr | input | 32 | Local-bus request address |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_addr | output | 32 | Translated PCI address |
| out_win | output | 3 | Index of the matching window |
| out_is_mem | output | 1 | 1: PCI memory space, 0: PCI I/O space |
| out_miss | output | 1 | No active window matched |
| vec_we | input | 1 | Vector register write strobe |
| vec_idx | input | 3 | Window whose vector register is written |
| vec_wdata | input | 32 | New translation vector |

## Verification
The hardest case to reach from the ports is a result held across a stall while a new address waits behind it. The stimulus fills the output register, drops out_ready, and then offers a second address while watching in_ready and the held output for several cycles. A second such case is an address that falls in a window that exists in the parameter set but lies above NUM_WIN. To reach it, a second instance is built with five active windows and register-sourced vectors. Both instances receive the same address sequence, which runs through overlapping windows, each window's base and high edge, the address just below a base, and back-to-back misses. This shows that a miss leaves the earlier translation in place, and that vector writes reach one configuration and are ignored by the other.

// File: rtl/pwx_pkg.sv
`timescale 1ns/1ps
package pwx_pkg;
  localparam int AW      = 32;
  localparam int MAX_WIN = 6;
  localparam int IDX_W   = $clog2(MAX_WIN);

  typedef logic [AW-1:0] addr_t;

  // Bits from the top that base and high agree on; these are substituted.
  function automatic addr_t prefix_mask(input addr_t b, input addr_t h);
    addr_t m;
    logic  same;
    same = 1'b1;
    for (int i = AW - 1; i >= 0; i--) begin
      same = same & (b[i] == h[i]);
      m[i] = same;
    end
    return m;
  endfunction
endpackage

// File: rtl/pwx_win_match.sv
`timescale 1ns/1ps
module pwx_win_match
  import pwx_pkg::*;
#(
  parameter addr_t BASE = '0,
  parameter addr_t HIGH = '1
) (
  input  addr_t addr,
  input  addr_t vec,
  output logic  hit,
  output addr_t xaddr
);
  localparam addr_t MASK = prefix_mask(BASE, HIGH);

  assign hit   = ((addr ^ BASE) & MASK) == '0;
  assign xaddr = (vec & MASK) | (addr & ~MASK);
endmodule

// File: rtl/pwx_vec_src.sv
`timescale 1ns/1ps
module pwx_vec_src
  import pwx_pkg::*;
#(
  parameter int                    NUM_WIN  = MAX_WIN,
  parameter bit                    USE_REG  = 1'b0,
  parameter addr_t [MAX_WIN-1:0]   VEC_INIT = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IDX_W-1:0]         idx,
  input  addr_t                    wdata,
  output addr_t [MAX_WIN-1:0]      vec
);
  addr_t reg_q [MAX_WIN];

  for (genvar g = 0; g < MAX_WIN; g++) begin : g_win
    if (g < NUM_WIN) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              reg_q[g] <= '0;
        else if (we && idx == IDX_W'(g))         reg_q[g] <= wdata;
      end
    end else begin : g_dead
      assign reg_q[g] = '0;
    end
  end

  always_comb begin
    for (int i = 0; i < MAX_WIN; i++)
      vec[i] = USE_REG ? reg_q[i] : VEC_INIT[i];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_REG && we && (int'(idx) < NUM_WIN)) |=> (vec[$past(idx)] == $past(wdata))) // R10
    else $error("vector write not visible");
endmodule

// File: rtl/pwx_prio_sel.sv
`timescale 1ns/1ps
module pwx_prio_sel
  import pwx_pkg::*;
#(
  parameter int                 NUM_WIN = MAX_WIN,
  parameter logic [MAX_WIN-1:0] WIN_MEM = '1
) (
  input  logic [MAX_WIN-1:0]    hit_raw,
  input  addr_t [MAX_WIN-1:0]   xaddr,
  output logic                  any,
  output logic [IDX_W-1:0]      pick,
  output addr_t                 addr,
  output logic                  mem
);
  logic [MAX_WIN-1:0] hit_eff;
  logic [MAX_WIN-1:0] grant;

  for (genvar g = 0; g < MAX_WIN; g++) begin : g_gate
    if (g < NUM_WIN) begin : g_on
      assign hit_eff[g] = hit_raw[g];
    end else begin : g_off
      assign hit_eff[g] = 1'b0;
    end
  end

  always_comb begin
    any   = 1'b0;
    pick  = '0;
    grant = '0;
    for (int i = 0; i < MAX_WIN; i++) begin
      if (hit_eff[i] && !any) begin
        any      = 1'b1;
        pick     = IDX_W'(i);
        grant[i] = 1'b1;
      end
    end
    addr = xaddr[pick];
    mem  = WIN_MEM[pick];
  end

  always_comb begin
    AST_GRANT_ONEHOT: assert ($onehot0(grant)) // R5
      else $error("more than one window granted");
  end
endmodule

// File: rtl/pci_window_xlate.sv
`timescale 1ns/1ps
module pci_window_xlate
  import pwx_pkg::*;
#(
  parameter int                 NUM_WIN     = 6,
  parameter bit                 USE_REG_VEC = 1'b0,
  parameter addr_t [MAX_WIN-1:0] WIN_BASE = {32'h2000_0000, 32'h1230_0000, 32'h0000_0000,
                                             32'hFE00_0000, 32'hABCD_E000, 32'h1234_0000},
  parameter addr_t [MAX_WIN-1:0] WIN_HIGH = {32'h2000_FFFF, 32'h123F_FFFF, 32'h0000_007F,
                                             32'hFFFF_FFFF, 32'hABCD_FFFF, 32'h1234_FFFF},
  parameter addr_t [MAX_WIN-1:0] WIN_VEC  = {32'h3333_0000, 32'h9AB0_0000, 32'h8765_4380,
                                             32'h4000_0000, 32'hFEDC_0000, 32'h5671_0000},
  parameter logic [MAX_WIN-1:0]  WIN_MEM  = 6'b100101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [AW-1:0]    in_addr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [AW-1:0]    out_addr,
  output logic [IDX_W-1:0] out_win,
  output logic             out_is_mem,
  output logic             out_miss,
  input  logic             vec_we,
  input  logic [IDX_W-1:0] vec_idx,
  input  logic [AW-1:0]    vec_wdata
);
  addr_t [MAX_WIN-1:0] vec;
  addr_t [MAX_WIN-1:0] xaddr;
  logic  [MAX_WIN-1:0] hit_raw;
  logic                sel_any;
  logic [IDX_W-1:0]    sel_pick;
  addr_t               sel_addr;
  logic                sel_mem;
  logic                accept;

  pwx_vec_src #(
    .NUM_WIN (NUM_WIN),
    .USE_REG (USE_REG_VEC),
    .VEC_INIT(WIN_VEC)
  ) u_vec (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (vec_we),
    .idx  (vec_idx),
    .wdata(vec_wdata),
    .vec  (vec)
  );

  for (genvar g = 0; g < MAX_WIN; g++) begin : g_match
    pwx_win_match #(
      .BASE(WIN_BASE[g]),
      .HIGH(WIN_HIGH[g])
    ) u_match (
      .addr (in_addr),
      .vec  (vec[g]),
      .hit  (hit_raw[g]),
      .xaddr(xaddr[g])
    );
  end

  pwx_prio_sel #(
    .NUM_WIN(NUM_WIN),
    .WIN_MEM(WIN_MEM)
  ) u_sel (
    .hit_raw(hit_raw),
    .xaddr  (xaddr),
    .any    (sel_any),
    .pick   (sel_pick),
    .addr   (sel_addr),
    .mem    (sel_mem)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_miss   <= 1'b0;
      out_addr   <= '0;
      out_win    <= '0;
      out_is_mem <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_miss  <= !sel_any;
      if (sel_any) begin
        out_addr   <= sel_addr;
        out_win    <= sel_pick;
        out_is_mem <= sel_mem;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_win) && $stable(out_miss))) // R8
    else $error("output moved during stall");

  AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sel_any) |=> (out_miss && $stable(out_addr) && $stable(out_win) && $stable(out_is_mem))) // R6
    else $error("miss disturbed held result");

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid) // R7
    else $error("result not valid one cycle after accept");

  AST_WIN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_miss) |-> (int'(out_win) < NUM_WIN)) // R1
    else $error("inactive window reported");
endmodule

// File: tb/pci_window_xlate_bench.sv
`timescale 1ns/1ps
module pci_window_xlate_bench;
  import pwx_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic        out_ready = 1'b1;
  logic        vec_we = 1'b0;
  logic [2:0]  vec_idx = '0;
  logic [31:0] vec_wdata = '0;

  logic        a_in_ready, a_out_valid, a_out_is_mem, a_out_miss;
  logic [31:0] a_out_addr;
  logic [2:0]  a_out_win;
  logic        b_in_ready, b_out_valid, b_out_is_mem, b_out_miss;
  logic [31:0] b_out_addr;
  logic [2:0]  b_out_win;

  always #2 clk = ~clk;

  pci_window_xlate u_pci_window_xlate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(a_in_ready), .in_addr(in_addr),
    .out_valid(a_out_valid), .out_ready(out_ready), .out_addr(a_out_addr), .out_win(a_out_win),
    .out_is_mem(a_out_is_mem), .out_miss(a_out_miss),
    .vec_we(vec_we), .vec_idx(vec_idx), .vec_wdata(vec_wdata));

  pci_window_xlate #(.NUM_WIN(5), .USE_REG_VEC(1'b1)) u_pci_window_xlate_rv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(b_in_ready), .in_addr(in_addr),
    .out_valid(b_out_valid), .out_ready(out_ready), .out_addr(b_out_addr), .out_win(b_out_win),
    .out_is_mem(b_out_is_mem), .out_miss(b_out_miss),
    .vec_we(vec_we), .vec_idx(vec_idx), .vec_wdata(vec_wdata));

  typedef struct {
    logic [31:0] addr;
    logic [2:0]  win;
    logic        mem;
    logic        miss;
    string       tag;
  } exp_t;

  int   checks = 0;
  int   failures = 0;
  bit   ended = 1'b0;
  exp_t qa[$];
  exp_t qb[$];
  exp_t last_a, last_b;
  logic [31:0] t_base [6];
  logic [31:0] t_high [6];
  logic        t_mem  [6];
  logic [31:0] va [6];
  logic [31:0] vb [6];

  initial begin
    t_base = '{32'h1234_0000, 32'hABCD_E000, 32'hFE00_0000, 32'h0000_0000, 32'h1230_0000, 32'h2000_0000};
    t_high = '{32'h1234_FFFF, 32'hABCD_FFFF, 32'hFFFF_FFFF, 32'h0000_007F, 32'h123F_FFFF, 32'h2000_FFFF};
    t_mem  = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    va     = '{32'h5671_0000, 32'hFEDC_0000, 32'h4000_0000, 32'h8765_4380, 32'h9AB0_0000, 32'h3333_0000};
    vb     = '{default: 32'h0};
    last_a = '{addr: 32'h0, win: 3'd0, mem: 1'b0, miss: 1'b0, tag: ""};
    last_b = last_a;
  end

  // Model: size mask from high-base, scan from top index so lowest wins.
  function automatic exp_t predict(input logic [31:0] a, input int nw, input logic [31:0] v [6],
                                   input exp_t prev, input string tag);
    exp_t        e;
    logic [31:0] m;
    e      = prev;
    e.tag  = tag;
    e.miss = 1'b1;
    for (int i = nw - 1; i >= 0; i--) begin
      m = ~(t_high[i] - t_base[i]);
      if ((a & m) == (t_base[i] & m)) begin
        e.miss = 1'b0;
        e.win  = 3'(i);
        e.mem  = t_mem[i];
        e.addr = (v[i] & m) | (a & ~m);
      end
    end
    return e;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cmp(input string who, input exp_t e, input logic [31:0] addr, input logic [2:0] win,
                     input logic mem, input logic miss);
    checks++;
    if (addr !== e.addr || win !== e.win || mem !== e.mem || miss !== e.miss) begin
      failures++;
      $display("FAIL %s %s: actual addr=%h win=%0d mem=%b miss=%b expected addr=%h win=%0d mem=%b miss=%b",
               e.tag, who, addr, win, mem, miss, e.addr, e.win, e.mem, e.miss);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: pop expected result whenever a result is taken.
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (a_out_valid && out_ready) begin
        if (qa.size() == 0) begin
          checks++; failures++;
          $display("FAIL R7 A: actual=unexpected result expected=none");
        end else begin
          e = qa.pop_front();
          cmp("A", e, a_out_addr, a_out_win, a_out_is_mem, a_out_miss);
        end
      end
      if (b_out_valid && out_ready) begin
        if (qb.size() == 0) begin
          checks++; failures++;
          $display("FAIL R7 B: actual=unexpected result expected=none");
        end else begin
          e = qb.pop_front();
          cmp("B", e, b_out_addr, b_out_win, b_out_is_mem, b_out_miss);
        end
      end
    end
  end

  task automatic send(input logic [31:0] a, input string ta, input string tb);
    bit taken;
    taken    = 1'b0;
    in_valid = 1'b1;
    in_addr  = a;
    while (!taken) begin
      @(negedge clk);
      if (a_in_ready) begin
        last_a = predict(a, 6, va, last_a, ta);
        qa.push_back(last_a);
        last_b = predict(a, 5, vb, last_b, tb);
        qb.push_back(last_b);
        taken = 1'b1;
      end
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] data);
    vec_we    = 1'b1;
    vec_idx   = idx;
    vec_wdata = data;
    @(posedge clk);
    #1;
    vec_we = 1'b0;
    if (idx < 3'd5) vb[idx] = data;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "valid in reset", {31'b0, a_out_valid}, 32'h0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "A valid", {31'b0, a_out_valid}, 32'h0);
    chk("R11", "A addr", a_out_addr, 32'h0);
    chk("R11", "A flags", {28'b0, a_out_win, a_out_is_mem}, 32'h0);
    chk("R11", "B miss", {31'b0, b_out_miss}, 32'h0);
    chk("R8", "ready when empty", {31'b0, a_in_ready}, 32'h1);
    @(posedge clk); #1;

    // R10: register vectors start at zero
    send(32'h1234_0ABC, "R3", "R10");
    wr(3'd0, 32'hCAFE_0000);
    wr(3'd1, 32'h1111_2000);
    wr(3'd2, 32'h7E00_0000);
    wr(3'd3, 32'h2468_0000);
    wr(3'd4, 32'h5550_0000);

    send(32'h1234_0ABC, "R5", "R10");
    send(32'hABCD_F123, "R3", "R10");
    send(32'hFFFE_DCBA, "R3", "R10");
    send(32'h0000_0071, "R3", "R10");
    send(32'h1235_5555, "R4", "R10");
    send(32'h2000_1234, "R9", "R1");
    send(32'h5000_0000, "R6", "R6");
    send(32'h6000_0000, "R6", "R6");
    send(32'hABCD_DFFF, "R2", "R2");
    send(32'hABCD_E000, "R2", "R2");
    send(32'hFFFF_FFFF, "R2", "R2");
    send(32'h1234_FFFF, "R2", "R2");
    send(32'h1235_0000, "R5", "R5");

    // R8: stall with a second address waiting
    repeat (3) @(posedge clk);
    #1 out_ready = 1'b0;
    send(32'h0000_0071, "R8", "R8");
    fork
      send(32'hABCD_F123, "R8", "R8");
      begin
        repeat (3) begin
          @(negedge clk);
          chk("R8", "ready during stall", {31'b0, a_in_ready}, 32'h0);
          chk("R8", "held addr", a_out_addr, 32'h8765_43F1);
          chk("R8", "held valid", {31'b0, a_out_valid}, 32'h1);
        end
        @(posedge clk);
        #1 out_ready = 1'b1;
      end
    join

    repeat (3) @(negedge clk);
    chk("R7", "A drained", {31'b0, a_out_valid}, 32'h0);
    chk("R7", "A queue", 32'(qa.size()), 32'h0);
    chk("R7", "B queue", 32'(qb.size()), 32'h0);
    finish_run();
  end
endmodule